// File: doc/BRIEF.md
# Banked Memory Expansion Windows

This block widens a 16-bit CPU address space by mapping two relocatable windows onto a larger physical memory built from 8 KB pages. The low 13 address bits always go straight to memory. When the current CPU address lands inside an enabled window, that window's bank register supplies the upper physical page bits on six extra address lines (physical bits 18 to 13).

Each window has its own size (off, 8 KB, 16 KB or 32 KB) and its own base page inside the CPU space. A window spanning several pages takes its high bank bits from the register and its low bank bits from the page offset inside the window, so one window reaches a contiguous block of physical pages. A pin-enable mask lets each expansion line be turned on separately; a disabled line stays low. Software programs the windows through a small synchronous write port with an asynchronous read-back path.

Top module: `xw_expander`

## Requirements
- R1: `addr_lo` always equals `cpu_addr[12:0]`, whatever the configuration.
- R2: Register 0 holds window 0 size in bits [1:0] and window 1 size in bits [5:4]; code 0 disables the window, 1 selects 8 KB (one page), 2 selects 16 KB (two pages), 3 selects 32 KB (four pages). A disabled window never hits.
- R3: Register 1 holds window 0 base page in bits [2:0] and window 1 base page in bits [6:4]; the window starts at the base page rounded down to a multiple of its page count, and covers the addresses whose page `cpu_addr[15:13]` falls within that aligned span.
- R4: Registers 2 and 3 hold the 6-bit bank of window 0 and window 1 in bits [5:0]; on a hit `xa` equals the bank rounded down to a multiple of the window's page count plus the page offset of `cpu_addr` inside the window.
- R5: When both windows cover the address, window 0 is used; `win_hit` has bit 0 for window 0 and bit 1 for window 1 and never has more than one bit set.
- R6: An address outside both windows gives `xa` = 0 and `win_hit` = 0.
- R7: Register 4 bits [5:0] enable the expansion lines one by one; `xa[i]` is 0 whenever enable bit i is 0.
- R8: `reg_rdata` returns the stored fields of the register at `reg_addr` at their positions, with every unused bit zero (bits [7:6] of registers 2, 3 and 4 included); addresses 5 to 7 read as zero.
- R9: Synchronous reset clears every register, so both windows are disabled and all lines are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| addr_lo | output | 13 | Pass-through low address bits |
| xa | output | 6 | Expansion address lines (physical bits 18:13) |
| win_hit | output | 2 | Selected window, one bit per window |

## Verification
The checker watches on every cycle that a miss drives the expansion lines low, that at most one hit bit is set, that a window with size code 0 never hits, that masked lines stay low, that unused bank read-back bits are zero and that leaving reset leaves no window active. The page arithmetic itself (base alignment, bank rounding plus page offset, priority on overlap) is shown only by the bench, whose arithmetic reference model is compared with every output each clock while address sweeps run over all eight pages under several window layouts.

// File: rtl/xw_pkg.sv
package xw_pkg;
    localparam int CPU_AW    = 16;
    localparam int PAGE_BITS = 13;
    localparam int SEL_W     = CPU_AW - PAGE_BITS;
    localparam int XA_W      = 6;
    localparam int NUM_WIN   = 2;
    localparam int RA_W      = 3;
    localparam int RD_W      = 8;
    localparam int FIELD_STEP = 4;

    localparam logic [RA_W-1:0] REG_SIZE  = 3'd0;
    localparam logic [RA_W-1:0] REG_BASE  = 3'd1;
    localparam logic [RA_W-1:0] REG_BANK0 = 3'd2;
    localparam logic [RA_W-1:0] REG_PINS  = 3'd4;

    typedef enum logic [1:0] {
        WSZ_OFF = 2'd0,
        WSZ_8K  = 2'd1,
        WSZ_16K = 2'd2,
        WSZ_32K = 2'd3
    } wsize_e;

    typedef struct packed {
        wsize_e            size;
        logic [SEL_W-1:0]  base;
        logic [XA_W-1:0]   bank;
    } win_cfg_t;

    // Page bits that must match the base for a given window size.
    function automatic logic [SEL_W-1:0] page_mask(input wsize_e s);
        logic [SEL_W-1:0] m;
        case (s)
            WSZ_8K:  m = {SEL_W{1'b1}};
            WSZ_16K: m = {{(SEL_W-1){1'b1}}, 1'b0};
            WSZ_32K: m = {{(SEL_W-2){1'b1}}, 2'b00};
            default: m = '0;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/xw_regs.sv
module xw_regs
    import xw_pkg::*;
#(
    parameter int N_WIN = NUM_WIN
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr,
    input  logic [RA_W-1:0]            addr,
    input  logic [RD_W-1:0]            wdata,
    output logic [RD_W-1:0]            rdata,
    output win_cfg_t [N_WIN-1:0]       cfg,
    output logic [XA_W-1:0]            pin_en
);
    wsize_e           size_q [N_WIN];
    logic [SEL_W-1:0] base_q [N_WIN];
    logic [XA_W-1:0]  bank_q [N_WIN];
    logic [XA_W-1:0]  pin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < N_WIN; w++) begin
                size_q[w] <= WSZ_OFF;
                base_q[w] <= '0;
                bank_q[w] <= '0;
            end
            pin_q <= '0;
        end else if (wr) begin
            for (int w = 0; w < N_WIN; w++) begin
                if (addr == REG_SIZE)
                    size_q[w] <= wsize_e'(wdata[FIELD_STEP*w +: 2]);
                if (addr == REG_BASE)
                    base_q[w] <= wdata[FIELD_STEP*w +: SEL_W];
                if (addr == REG_BANK0 + RA_W'(w))
                    bank_q[w] <= wdata[XA_W-1:0];
            end
            if (addr == REG_PINS)
                pin_q <= wdata[XA_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        for (int w = 0; w < N_WIN; w++) begin
            if (addr == REG_SIZE)
                rdata[FIELD_STEP*w +: 2] = size_q[w];
            if (addr == REG_BASE)
                rdata[FIELD_STEP*w +: SEL_W] = base_q[w];
            if (addr == REG_BANK0 + RA_W'(w))
                rdata[XA_W-1:0] = bank_q[w];
        end
        if (addr == REG_PINS)
            rdata[XA_W-1:0] = pin_q;
    end

    generate
        for (genvar g = 0; g < N_WIN; g++) begin : g_cfg
            assign cfg[g] = '{size: size_q[g], base: base_q[g], bank: bank_q[g]};
        end
    endgenerate
    assign pin_en = pin_q;
endmodule

// File: rtl/xw_match.sv
module xw_match
    import xw_pkg::*;
(
    input  win_cfg_t          cfg,
    input  logic [SEL_W-1:0]  page,
    output logic              hit,
    output logic [XA_W-1:0]   xa_raw
);
    logic [SEL_W-1:0] mask;

    always_comb begin
        mask   = page_mask(cfg.size);
        hit    = (cfg.size != WSZ_OFF) && (((page ^ cfg.base) & mask) == '0);
        xa_raw = cfg.bank;
        xa_raw[SEL_W-1:0] = (cfg.bank[SEL_W-1:0] & mask) | (page & ~mask);
    end
endmodule

// File: rtl/xw_select.sv
module xw_select
    import xw_pkg::*;
#(
    parameter int N_WIN = NUM_WIN
) (
    input  logic [N_WIN-1:0]             hit,
    input  logic [N_WIN-1:0][XA_W-1:0]   xa_raw,
    input  logic [XA_W-1:0]              pin_en,
    output logic [N_WIN-1:0]             win_hit,
    output logic [XA_W-1:0]              xa
);
    logic [XA_W-1:0] xa_sel;

    // Lowest-numbered window has priority: scan from the top down.
    always_comb begin
        win_hit = '0;
        xa_sel  = '0;
        for (int w = N_WIN - 1; w >= 0; w--) begin
            if (hit[w]) begin
                win_hit    = '0;
                win_hit[w] = 1'b1;
                xa_sel     = xa_raw[w];
            end
        end
        xa = xa_sel & pin_en;
    end
endmodule

// File: rtl/xw_expander.sv
module xw_expander
    import xw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CPU_AW-1:0]     cpu_addr,
    input  logic                  reg_wr,
    input  logic [RA_W-1:0]       reg_addr,
    input  logic [RD_W-1:0]       reg_wdata,
    output logic [RD_W-1:0]       reg_rdata,
    output logic [PAGE_BITS-1:0]  addr_lo,
    output logic [XA_W-1:0]       xa,
    output logic [NUM_WIN-1:0]    win_hit
);
    win_cfg_t [NUM_WIN-1:0]            cfg;
    logic [XA_W-1:0]                   pin_en;
    logic [NUM_WIN-1:0]                hit;
    logic [NUM_WIN-1:0][XA_W-1:0]      xa_raw;

    xw_regs #(.N_WIN(NUM_WIN)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .cfg    (cfg),
        .pin_en (pin_en)
    );

    generate
        for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
            xw_match u_match (
                .cfg    (cfg[g]),
                .page   (cpu_addr[CPU_AW-1:PAGE_BITS]),
                .hit    (hit[g]),
                .xa_raw (xa_raw[g])
            );
        end
    endgenerate

    xw_select #(.N_WIN(NUM_WIN)) u_sel (
        .hit     (hit),
        .xa_raw  (xa_raw),
        .pin_en  (pin_en),
        .win_hit (win_hit),
        .xa      (xa)
    );

    assign addr_lo = cpu_addr[PAGE_BITS-1:0];
endmodule

// File: rtl/xw_expander_chk.sv
module xw_expander_chk
    import xw_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [RA_W-1:0]          reg_addr,
    input  logic [RD_W-1:0]          reg_rdata,
    input  logic [XA_W-1:0]          xa,
    input  logic [NUM_WIN-1:0]       win_hit,
    input  win_cfg_t [NUM_WIN-1:0]   cfg,
    input  logic [XA_W-1:0]          pin_en
);
    a_r6_miss_lines_low: assert property (@(posedge clk) disable iff (rst)
        (win_hit == '0) |-> (xa == '0));

    a_r5_single_hit: assert property (@(posedge clk) disable iff (rst)
        $onehot0(win_hit));

    a_r2_off_win0: assert property (@(posedge clk) disable iff (rst)
        (cfg[0].size == WSZ_OFF) |-> !win_hit[0]);

    a_r2_off_win1: assert property (@(posedge clk) disable iff (rst)
        (cfg[1].size == WSZ_OFF) |-> !win_hit[1]);

    a_r7_pin_mask: assert property (@(posedge clk) disable iff (rst)
        ((xa & ~pin_en) == '0));

    a_r8_bank_top_zero: assert property (@(posedge clk) disable iff (rst)
        ((reg_addr == REG_BANK0) || (reg_addr == REG_BANK0 + 3'd1)) |->
            (reg_rdata[RD_W-1:XA_W] == '0));

    a_r9_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ((win_hit == '0) && (xa == '0)));
endmodule

bind xw_expander xw_expander_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .xa        (xa),
    .win_hit   (win_hit),
    .cfg       (cfg),
    .pin_en    (pin_en)
);

// File: tb/xw_expander_bench.sv
module xw_expander_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [12:0] addr_lo;
    logic [5:0]  xa;
    logic [1:0]  win_hit;

    int checks = 0;
    int errors = 0;
    int sz[2], bs[2], bk[2];
    int pins = 0;
    string cur_req = "R9";
    bit cmp_on = 1'b0;

    always #4 clk = ~clk;

    xw_expander u_xw_expander (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .addr_lo(addr_lo), .xa(xa), .win_hit(win_hit)
    );

    // Arithmetic reference: window spans, aligned starts, bank plus page offset.
    function automatic void model(input int a, output int xe, output int he);
        xe = 0; he = 0;
        for (int w = 1; w >= 0; w--) begin
            if (sz[w] != 0) begin
                int n, span, start;
                n = 1 << (sz[w] - 1);
                span = n * 8192;
                start = ((bs[w] * 8192) / span) * span;
                if (a >= start && a < start + span) begin
                    he = 1 << w;
                    xe = (bk[w] / n) * n + (a - start) / 8192;
                end
            end
        end
        xe = xe & pins;
    endfunction

    function automatic int exp_read(input int ra);
        case (ra)
            0: return sz[0] | (sz[1] << 4);
            1: return bs[0] | (bs[1] << 4);
            2: return bk[0];
            3: return bk[1];
            4: return pins;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Compared on every clock, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            int xe, he;
            model(int'(cpu_addr), xe, he);
            chk("R1", "addr_lo", int'(addr_lo), int'(cpu_addr) % 8192);
            chk(cur_req, "xa", int'(xa), xe);
            chk(cur_req, "win_hit", int'(win_hit), he);
            chk("R8", "reg_rdata", int'(reg_rdata), exp_read(int'(reg_addr)));
        end
    end

    task automatic wr_reg(input int ra, input int d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = 3'(ra); reg_wdata = 8'(d);
        @(posedge clk);
        case (ra)
            0: begin sz[0] = d & 3; sz[1] = (d >> 4) & 3; end
            1: begin bs[0] = d & 7; bs[1] = (d >> 4) & 7; end
            2: bk[0] = d & 63;
            3: bk[1] = d & 63;
            4: pins = d & 63;
            default: ;
        endcase
        #1 reg_wr = 1'b0;
    endtask

    task automatic sweep(input int salt);
        for (int i = 0; i < 64; i++) begin
            @(posedge clk); #1;
            cpu_addr = 16'(i * 1024 + (i * 37 + salt) % 1024);
            reg_addr = 3'(i % 8);
        end
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int w = 0; w < 2; w++) begin sz[w] = 0; bs[w] = 0; bk[w] = 0; end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R9", "win_hit after reset", int'(win_hit), 0);
        chk("R9", "xa after reset", int'(xa), 0);
        cmp_on = 1'b1;
        // R9 / R6: everything disabled after reset
        cur_req = "R9"; sweep(3);
        // R6: banks and pins set but both windows off
        wr_reg(4, 8'h3F); wr_reg(2, 8'h2A); wr_reg(3, 8'h15);
        cur_req = "R6"; sweep(11);
        // R2 / R4: window 0 8 KB at page 5
        wr_reg(1, 8'h05); wr_reg(0, 8'h01);
        cur_req = "R4"; sweep(5);
        // R3: 16 KB with odd base, start rounds down to page 4
        wr_reg(0, 8'h02);
        cur_req = "R3"; sweep(17);
        // R4: 32 KB at page 6, bank 0x2F rounds to 0x2C
        wr_reg(1, 8'h06); wr_reg(2, 8'h2F); wr_reg(0, 8'h03);
        cur_req = "R4"; sweep(29);
        // R5: overlap, window 0 8 KB at page 3 inside window 1 16 KB at page 2
        wr_reg(1, 8'h23); wr_reg(0, 8'h21);
        cur_req = "R5"; sweep(41);
        // R7: only the low four lines enabled
        wr_reg(4, 8'h0F);
        cur_req = "R7"; sweep(7);
        // R8: unused bits written as ones read back as zero
        wr_reg(2, 8'hFF); wr_reg(3, 8'hC0); wr_reg(4, 8'hFF); wr_reg(1, 8'hFF);
        cur_req = "R8"; sweep(13);
        wr_reg(0, 8'hFF);
        for (int ra = 0; ra < 8; ra++) begin
            @(posedge clk); #1 reg_addr = 3'(ra);
            @(negedge clk);
            chk("R8", "explicit read", int'(reg_rdata), exp_read(ra));
        end
        chk("R2", "size register read", int'(reg_rdata), 0);
        reg_addr = 3'd0; #1;
        chk("R2", "size fields", int'(reg_rdata), 8'h33);
        cur_req = "R2"; sweep(19);
        // R2: window 1 off, window 0 on
        wr_reg(0, 8'h02);
        cur_req = "R2"; sweep(23);
        // R9: reset again clears all
        @(posedge clk); #1 rst = 1'b1; cmp_on = 1'b0;
        @(posedge clk); #1 rst = 1'b0;
        for (int w = 0; w < 2; w++) begin sz[w] = 0; bs[w] = 0; bk[w] = 0; end
        pins = 0;
        cmp_on = 1'b1;
        cur_req = "R9"; sweep(31);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule